// File: doc/BRIEF.md
# Spread Spectrum Sweep Profile Generator

This block runs on the input clock and produces a signed frequency-offset word that follows a periodic triangular sweep. A fractional feedback divider further down the clock path takes this word and spreads the synthesized clock, which lowers the peak energy of its harmonics. The analog loop, the oscillator and the divider are built elsewhere. This block covers only the digital sweep, the timing of its period and the decoding of the static select pins.

Three kinds of static selects shape the sweep. A two-bit band select fixes the sweep period as a whole number of input clock cycles. A two-bit deviation select sets the peak-to-peak excursion. A mode bit picks one of two placements: down spread, where the excursion lies entirely below nominal, or center spread, where it is split evenly about zero. An active-low halt input stops the sweep and reports standby. A constant flag marks the reference clock path as never modulated. Select changes are sampled only when the sweep wraps to phase zero, or while the block is halted, so one sweep never mixes two settings.

The output unit is 1/16 of a 0.125 % step. The output word is therefore (offset in percent) × 128.

Top module: `ssm_sweep_gen`

## Requirements
- R1: The sweep period is P input clock cycles, where band_sel_i gives P = 256 for 00, 512 for 01, 2048 for 10 and 3584 for 11. A running sweep at phase p moves to phase p+1 on each clock edge and wraps from P-1 to 0.
- R2: dev_sel_i sets the span in 0.125 % units: 00 gives 10, 01 gives 20, 10 gives 14 and 11 gives 28. The span S in output units is the unit count × 16.
- R3: With center_i = 0 (down spread), offset_o = -m(p), so the output stays between -S and 0.
- R4: With center_i = 1 (center spread), offset_o = S/2 - m(p), so the output stays between +S/2 and -S/2.
- R5: With H = P/2, the magnitude is m(p) = floor(S·p/H) for p < H and m(p) = S - floor(S·(p-H)/H) for p ≥ H. The sweep reaches 0 at p = 0 and exactly S at p = H.
- R6: If halt_ni is low at a clock edge, then after that edge standby_o = 1, the phase is 0 and offset_o holds the start value of the current selects. The first edge with halt_ni high moves the phase to 1 and clears standby_o.
- R7: A change on band_sel_i, dev_sel_i or center_i while the block is running takes effect only at the edge where the phase wraps from P-1 to 0.
- R8: After reset, standby_o = 0, the phase is 0 and the selects are taken as all high (P = 3584, S = 448, center spread), so offset_o = +224.
- R9: ref_unmod_o is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_ni | input | 1 | Power-down, active low; stops the sweep |
| band_sel_i | input | 2 | Sweep period select |
| dev_sel_i | input | 2 | Deviation select; bit 1 selects the wide range |
| center_i | input | 1 | 0 selects down spread, 1 selects center spread |
| offset_o | output | OFS_W | Signed frequency offset, 1/128 % per LSB |
| standby_o | output | 1 | High while the sweep is halted |
| ref_unmod_o | output | 1 | Constant flag: the reference path is never modulated |

## Verification
The hardest case to reach from the ports is a select change that arrives mid-sweep. The bench must show that the new setting stays hidden until the wrap, and that the first sample after the wrap uses the new period and span. To reach this, the bench first parks the block in standby so that a known setting loads. It then releases halt, changes all selects about a hundred cycles into the sweep, and checks every cycle against a phase model that follows the rules above. A second scenario drops halt in the middle of a sweep and checks that the sweep restarts from phase zero.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef struct packed {
    logic [1:0] band;
    logic [1:0] dev;
    logic       center;
  } ssm_sel_t;

  localparam int unsigned SPAN_UNITS_MAX = 28;

  // span in 0.125 % units; bit 1 = wide range
  function automatic int unsigned dev_units(input logic [1:0] code);
    case (code)
      2'b00:   return 10;
      2'b01:   return 20;
      2'b10:   return 14;
      default: return 28;
    endcase
  endfunction

  function automatic int unsigned min4(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    if (d < m) m = d;
    return m;
  endfunction

  function automatic int unsigned max4(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ssm_cfg.sv
module ssm_cfg
  import ssm_pkg::*;
#(
  parameter int unsigned DIV_0 = 256,
  parameter int unsigned DIV_1 = 512,
  parameter int unsigned DIV_2 = 2048,
  parameter int unsigned DIV_3 = 3584,
  parameter int unsigned FRAC  = 16,
  parameter int unsigned PH_W  = 12,
  parameter int unsigned S_W   = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  ssm_sel_t        sel_i,
  output ssm_sel_t        cfg_o,
  output logic [S_W-1:0]  span_o,
  output logic [PH_W-1:0] half_o,
  output logic [PH_W-1:0] last_o,
  output logic            center_o
);

  ssm_sel_t    sel_q;
  int unsigned div_sel;

  // selects idle high, as if pulled up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '1;
    else if (load_i) sel_q <= sel_i;
  end

  always_comb begin
    unique case (sel_q.band)
      2'd0: div_sel = DIV_0;
      2'd1: div_sel = DIV_1;
      2'd2: div_sel = DIV_2;
      2'd3: div_sel = DIV_3;
    endcase
    span_o = S_W'(dev_units(sel_q.dev) * FRAC);
    half_o = PH_W'(div_sel / 2);
    last_o = PH_W'(div_sel - 1);
  end

  assign center_o = sel_q.center;
  assign cfg_o    = sel_q;

endmodule

// File: rtl/ssm_phase.sv
module ssm_phase #(
  parameter int unsigned PH_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PH_W-1:0] half_i,
  input  logic [PH_W-1:0] last_i,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o,
  output logic            mid_o,
  output logic            fall_o
);

  assign wrap_o = run_i && (phase_o == last_i);
  assign mid_o  = run_i && (phase_o == half_i - 1'b1);
  assign fall_o = phase_o >= half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_o <= '0;
    else if (!run_i || wrap_o)  phase_o <= '0;
    else                        phase_o <= phase_o + 1'b1;
  end

endmodule

// File: rtl/ssm_ramp.sv
// Exact linear ramp q = floor(span * j / half), advanced one j per cycle.
module ssm_ramp #(
  parameter int unsigned PH_W = 12,
  parameter int unsigned S_W  = 9,
  parameter int unsigned NSUB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [S_W-1:0]  span_i,
  input  logic [PH_W-1:0] half_i,
  output logic [S_W-1:0]  q_o
);

  localparam int unsigned T_W = PH_W + 1;

  logic [PH_W-1:0] rem_q;
  logic [T_W-1:0]  acc0;
  logic [T_W-1:0]  den;
  logic [NSUB-1:0] hit;

  assign acc0 = T_W'(rem_q) + T_W'(span_i);
  assign den  = {1'b0, half_i};

  // unrolled restoring subtract; NSUB bounds the quotient per step
  for (genvar i = 0; i < NSUB; i++) begin : g_sub
    logic [T_W-1:0] t_in;
    logic [T_W-1:0] t_out;
    if (i == 0) begin : g_first
      assign t_in = acc0;
    end else begin : g_next
      assign t_in = g_sub[i-1].t_out;
    end
    assign hit[i] = t_in >= den;
    assign t_out  = hit[i] ? t_in - den : t_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      rem_q <= '0;
    end else if (clr_i) begin
      q_o   <= '0;
      rem_q <= '0;
    end else if (adv_i) begin
      q_o   <= q_o + S_W'($countones(hit));
      rem_q <= PH_W'(g_sub[NSUB-1].t_out);
    end
  end

endmodule

// File: rtl/ssm_sweep_gen.sv
module ssm_sweep_gen
  import ssm_pkg::*;
#(
  parameter int unsigned DIV_0 = 256,
  parameter int unsigned DIV_1 = 512,
  parameter int unsigned DIV_2 = 2048,
  parameter int unsigned DIV_3 = 3584,
  parameter int unsigned FRAC  = 16,
  parameter int unsigned OFS_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    halt_ni,
  input  logic [1:0]              band_sel_i,
  input  logic [1:0]              dev_sel_i,
  input  logic                    center_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    standby_o,
  output logic                    ref_unmod_o
);

  localparam int unsigned DIV_MAX = max4(DIV_0, DIV_1, DIV_2, DIV_3);
  localparam int unsigned DIV_MIN = min4(DIV_0, DIV_1, DIV_2, DIV_3);
  localparam int unsigned PH_W    = $clog2(DIV_MAX);
  localparam int unsigned S_MAX   = SPAN_UNITS_MAX * FRAC;
  localparam int unsigned S_W     = $clog2(S_MAX + 1);
  localparam int unsigned H_MIN   = DIV_MIN / 2;
  localparam int unsigned NSUB    = (S_MAX + H_MIN - 1) / H_MIN;

  ssm_sel_t        sel_in;
  ssm_sel_t        cfg_q;
  logic [S_W-1:0]  span;
  logic [PH_W-1:0] half;
  logic [PH_W-1:0] last;
  logic            center;
  logic [PH_W-1:0] phase;
  logic            wrap;
  logic            mid;
  logic            fall;
  logic [S_W-1:0]  q;
  logic [S_W-1:0]  mag;
  logic            run;

  assign run    = halt_ni;
  assign sel_in = '{band: band_sel_i, dev: dev_sel_i, center: center_i};

  ssm_cfg #(
    .DIV_0(DIV_0), .DIV_1(DIV_1), .DIV_2(DIV_2), .DIV_3(DIV_3),
    .FRAC(FRAC), .PH_W(PH_W), .S_W(S_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (!run || wrap),
    .sel_i    (sel_in),
    .cfg_o    (cfg_q),
    .span_o   (span),
    .half_o   (half),
    .last_o   (last),
    .center_o (center)
  );

  ssm_phase #(.PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .half_i  (half),
    .last_i  (last),
    .phase_o (phase),
    .wrap_o  (wrap),
    .mid_o   (mid),
    .fall_o  (fall)
  );

  ssm_ramp #(.PH_W(PH_W), .S_W(S_W), .NSUB(NSUB)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run || wrap || mid),
    .adv_i  (run),
    .span_i (span),
    .half_i (half),
    .q_o    (q)
  );

  assign mag = fall ? span - q : q;

  always_comb begin
    logic signed [OFS_W-1:0] top_s;
    top_s    = center ? $signed(OFS_W'(span >> 1)) : '0;
    offset_o = top_s - $signed(OFS_W'(mag));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) standby_o <= 1'b0;
    else         standby_o <= !halt_ni;
  end

  assign ref_unmod_o = 1'b1;

endmodule

// File: rtl/ssm_sweep_chk.sv
module ssm_sweep_chk
  import ssm_pkg::*;
#(
  parameter int unsigned OFS_W = 12,
  parameter int unsigned PH_W  = 12,
  parameter int unsigned S_W   = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    halt_ni,
  input logic                    standby_i,
  input logic signed [OFS_W-1:0] offset_i,
  input logic [PH_W-1:0]         phase_i,
  input logic [PH_W-1:0]         half_i,
  input logic [S_W-1:0]          span_i,
  input logic                    center_i,
  input ssm_sel_t                cfg_i
);

  logic signed [OFS_W-1:0] full_s;
  logic signed [OFS_W-1:0] half_s;

  assign full_s = $signed(OFS_W'(span_i));
  assign half_s = $signed(OFS_W'(span_i >> 1));

  AST_DOWN_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !center_i |-> (offset_i <= 0 && offset_i >= -full_s)); // R3

  AST_CENTER_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    center_i |-> (offset_i <= half_s && offset_i >= -half_s)); // R4

  AST_RISE_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != '0 && phase_i < half_i) |-> offset_i <= $past(offset_i)); // R5

  AST_PEAK_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == half_i) |-> offset_i == (center_i ? -half_s : -full_s)); // R5

  AST_HALT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_ni |=> (standby_i && phase_i == '0)); // R6

  AST_CFG_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_i) |-> phase_i == '0); // R7

endmodule

bind ssm_sweep_gen ssm_sweep_chk #(.OFS_W(OFS_W), .PH_W(PH_W), .S_W(S_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .halt_ni   (halt_ni),
  .standby_i (standby_o),
  .offset_i  (offset_o),
  .phase_i   (phase),
  .half_i    (half),
  .span_i    (span),
  .center_i  (center),
  .cfg_i     (cfg_q)
);

// File: tb/sim_ssm_sweep_gen.sv
`timescale 1ns/1ps
module sim_ssm_sweep_gen;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              halt_ni = 1'b1;
  logic [1:0]        band_sel_i = 2'b11;
  logic [1:0]        dev_sel_i = 2'b11;
  logic              center_i = 1'b1;
  logic signed [11:0] offset_o;
  logic              standby_o;
  logic              ref_unmod_o;

  int checks = 0;
  int fails  = 0;

  // bench model state
  int m_p = 0;
  int m_band = 3;
  int m_dev = 3;
  int m_center = 1;
  int m_stb = 0;

  always #10 clk_i = ~clk_i;

  ssm_sweep_gen u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_ni     (halt_ni),
    .band_sel_i  (band_sel_i),
    .dev_sel_i   (dev_sel_i),
    .center_i    (center_i),
    .offset_o    (offset_o),
    .standby_o   (standby_o),
    .ref_unmod_o (ref_unmod_o)
  );

  function automatic int period_of(input int b);
    case (b)
      0: return 256;
      1: return 512;
      2: return 2048;
      default: return 3584;
    endcase
  endfunction

  function automatic int span_of(input int d);
    case (d)
      0: return 10 * 16;
      1: return 20 * 16;
      2: return 14 * 16;
      default: return 28 * 16;
    endcase
  endfunction

  function automatic int exp_offset();
    int h, s, m;
    h = period_of(m_band) / 2;
    s = span_of(m_dev);
    if (m_p < h) m = (s * m_p) / h;
    else         m = s - (s * (m_p - h)) / h;
    return m_center ? (s / 2 - m) : -m;
  endfunction

  task automatic check_val(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d (phase %0d)", tag, what, act, exp, m_p);
    end
  endtask

  // one clock edge: advance model, then compare at the falling edge
  task automatic tick(input string tag);
    @(posedge clk_i);
    if (!halt_ni) begin
      m_p = 0; m_stb = 1;
      m_band = int'(band_sel_i); m_dev = int'(dev_sel_i); m_center = int'(center_i);
    end else begin
      m_stb = 0;
      if (m_p == period_of(m_band) - 1) begin
        m_p = 0;
        m_band = int'(band_sel_i); m_dev = int'(dev_sel_i); m_center = int'(center_i);
      end else begin
        m_p++;
      end
    end
    @(negedge clk_i);
    check_val(tag, "offset", int'(offset_o), exp_offset());
    check_val(tag, "standby", int'(standby_o), m_stb);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk_i);
    check_val("R8", "offset", int'(offset_o), 224);
    check_val("R8", "standby", int'(standby_o), 0);
    check_val("R9", "ref_unmod", int'(ref_unmod_o), 1);
    rst_ni = 1'b1;
    for (int k = 0; k < 40; k++) tick("R8");
  endtask

  // park in standby with a setting, then sweep a number of periods
  task automatic t_profile(input logic [1:0] b, input logic [1:0] d, input logic c,
                           input int periods, input string tag);
    halt_ni = 1'b0; band_sel_i = b; dev_sel_i = d; center_i = c;
    tick("R6");
    tick("R6");
    halt_ni = 1'b1;
    for (int k = 0; k < periods * period_of(int'(b)) + 2; k++) tick(tag);
  endtask

  task automatic t_midchange();
    halt_ni = 1'b0; band_sel_i = 2'd0; dev_sel_i = 2'd0; center_i = 1'b0;
    tick("R6");
    halt_ni = 1'b1;
    for (int k = 0; k < 100; k++) tick("R7");
    band_sel_i = 2'd1; dev_sel_i = 2'd3; center_i = 1'b1;
    for (int k = 0; k < 156 + 512 + 4; k++) tick("R7");
  endtask

  task automatic t_halt_mid();
    halt_ni = 1'b0; band_sel_i = 2'd0; dev_sel_i = 2'd2; center_i = 1'b1;
    tick("R6");
    halt_ni = 1'b1;
    for (int k = 0; k < 60; k++) tick("R6");
    halt_ni = 1'b0;
    tick("R6");
    tick("R6");
    halt_ni = 1'b1;
    for (int k = 0; k < 300; k++) tick("R6");
    check_val("R9", "ref_unmod", int'(ref_unmod_o), 1);
  endtask

  initial begin
    t_reset();
    t_profile(2'd0, 2'd0, 1'b0, 2, "R1");
    t_profile(2'd1, 2'd1, 1'b1, 1, "R4");
    t_profile(2'd0, 2'd3, 1'b0, 1, "R3");
    t_profile(2'd0, 2'd2, 1'b1, 1, "R2");
    t_profile(2'd2, 2'd1, 1'b0, 1, "R5");
    t_profile(2'd3, 2'd3, 1'b1, 1, "R1");
    t_profile(2'd1, 2'd0, 1'b1, 1, "R2");
    t_midchange();
    t_halt_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: act=running exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule